// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the register-level front end of a simple serial port. A bus master reads and writes its registers with accesses of one, two or four bytes. Writes to the data register hand a byte to an outgoing character stream. Reads of the data register take the waiting byte from an incoming character stream. The remaining registers hold the two baud divisors, line control, port control, the FIFO trigger level and the interrupt mask. These values are stored and read back; the serial shifter, baud generation and FIFOs lie outside the block.

Three interrupt sources are tracked in a raw status register: receive, receive timeout and transmit. An event that sets a raw bit also starts a delay counter, unless the counter is already running. When the counter expires, the masked status is recomputed as mask AND raw, and the single interrupt line is raised if any of the three masked sources is set. Writing the clear register removes raw bits and recomputes the masked status. The line drops only when no masked source remains. When enabled, a transmitted byte of 0x04 produces an end-of-transmission pulse.

Top module: `uart_regfront`

## Requirements
- R1: After reset, reads give the following values. Control (offset 0x30) is 0x300. FIFO level (0x34) is 0x12. Integer divisor (0x24), fractional divisor (0x28), line control (0x2C), mask (0x38), raw status (0x3C) and masked status (0x40) are all 0. The interrupt output is low.
- R2: A write to the data register (0x00) drives `txValid` high for one cycle, starting the cycle after the write, with `txData` equal to the low 8 bits written. The same write sets raw status bit 5 (transmit) whatever the mask holds.
- R3: A write to the mask register with bit 5 set also sets raw bit 5 and starts a delayed evaluation.
- R4: A rising edge of `rxValid` sets raw bit 4 (receive) and raw bit 6 (receive timeout) and starts a delayed evaluation.
- R5: A delayed evaluation that is armed at clock edge N completes at edge N+DELAY. At that edge the masked status (0x40) becomes mask AND raw, and `irq` goes high if bit 4, 5 or 6 of that result is set.
- R6: An arming event while an evaluation is pending is ignored; it does not restart or extend the pending delay. A data write also arms the delay when mask bit 5 was already set before the write.
- R7: A write to the clear register (0x44) clears each raw bit written as 1 and sets masked status to the new raw AND mask. `irq` falls only if bits 4 to 6 of that result are all zero.
- R8: The flag register (0x18) reads bit 7 (transmit empty) = 1, bit 0 (clear to send) = 1, and bit 4 (receive empty) = NOT `rxValid`. All other bits read 0.
- R9: A read of the data register returns `rxData` when `rxValid` is high and 0 otherwise. During such a read with a byte waiting, `rxTake` is high.
- R10: `busSize` 0, 1 and 2 select byte, halfword and word access. Write data and read data are limited to the low 8, 16 or 32 bits. The integer divisor holds 16 bits.
- R11: The following accesses set `busErr` with read data 0 and change no state: `busSize` 3, an undecoded offset, a write to 0x18, 0x3C or 0x40, and a read of 0x44.
- R12: When `eotEnable` is high, a data write of 0x04 gives one `eotPulse` cycle aligned with `txValid`. No pulse is produced for other bytes or when `eotEnable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| busErr | output | 1 | Access rejected, same cycle |
| rxValid | input | 1 | A received byte is waiting |
| rxData | input | 8 | The waiting byte |
| rxTake | output | 1 | Waiting byte consumed by a data read |
| txValid | output | 1 | Outgoing byte strobe |
| txData | output | 8 | Outgoing byte |
| eotEnable | input | 1 | Enables end-of-transmission detection |
| eotPulse | output | 1 | 0x04 was transmitted |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DELAY set to 5. This makes the exact expiry edge of an evaluation cheap to check, and lets a second arming event land inside the pending window to show that it does not extend the delay. The short window also lets a receive arrival fall inside a transmit-armed wait, so the evaluation must pick up all three raw bits. A partial clear can then be checked to hold the line high while a full clear drops it.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;

  localparam logic [11:0] OFF_DATA = 12'h000;
  localparam logic [11:0] OFF_FLAG = 12'h018;
  localparam logic [11:0] OFF_IBRD = 12'h024;
  localparam logic [11:0] OFF_FBRD = 12'h028;
  localparam logic [11:0] OFF_LCRH = 12'h02C;
  localparam logic [11:0] OFF_CTRL = 12'h030;
  localparam logic [11:0] OFF_FLVL = 12'h034;
  localparam logic [11:0] OFF_MASK = 12'h038;
  localparam logic [11:0] OFF_RAW  = 12'h03C;
  localparam logic [11:0] OFF_MIS  = 12'h040;
  localparam logic [11:0] OFF_CLR  = 12'h044;

  localparam int unsigned INT_W   = 11;
  localparam int unsigned BIT_RX  = 4;
  localparam int unsigned BIT_TX  = 5;
  localparam int unsigned BIT_RT  = 6;
  localparam logic [INT_W-1:0] IRQ_SRC = 11'h070;

  localparam logic [31:0] CTRL_RST = 32'h0000_0300;
  localparam logic [5:0]  FLVL_RST = 6'h12;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_FLAG, SEL_IBRD, SEL_FBRD, SEL_LCRH,
    SEL_CTRL, SEL_FLVL, SEL_MASK, SEL_RAW, SEL_MIS, SEL_CLR
  } regSel_e;

  typedef struct packed {
    logic        wrData;
    logic        wrIbrd;
    logic        wrFbrd;
    logic        wrLcrh;
    logic        wrCtrl;
    logic        wrFlvl;
    logic        wrMask;
    logic        wrClr;
    logic        rdData;
    regSel_e     rdSel;
    logic [31:0] wdata;
  } strobes_t;

endpackage

// File: rtl/uart_front_ctrl.sv
module uart_front_ctrl
  import uart_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       regRdata,
  output strobes_t          strb,
  output logic [31:0]       busRdata,
  output logic              busErr
);

  regSel_e     sel;
  logic        rdOk;
  logic        wrOk;
  logic        accept;
  logic [31:0] sizeMask;

  always_comb begin
    sel  = SEL_NONE;
    rdOk = 1'b0;
    wrOk = 1'b0;
    case (busAddr)
      ADDR_W'(OFF_DATA): begin sel = SEL_DATA; rdOk = 1'b1; wrOk = 1'b1; end
      ADDR_W'(OFF_FLAG): begin sel = SEL_FLAG; rdOk = 1'b1; end
      ADDR_W'(OFF_IBRD): begin sel = SEL_IBRD; rdOk = 1'b1; wrOk = 1'b1; end
      ADDR_W'(OFF_FBRD): begin sel = SEL_FBRD; rdOk = 1'b1; wrOk = 1'b1; end
      ADDR_W'(OFF_LCRH): begin sel = SEL_LCRH; rdOk = 1'b1; wrOk = 1'b1; end
      ADDR_W'(OFF_CTRL): begin sel = SEL_CTRL; rdOk = 1'b1; wrOk = 1'b1; end
      ADDR_W'(OFF_FLVL): begin sel = SEL_FLVL; rdOk = 1'b1; wrOk = 1'b1; end
      ADDR_W'(OFF_MASK): begin sel = SEL_MASK; rdOk = 1'b1; wrOk = 1'b1; end
      ADDR_W'(OFF_RAW):  begin sel = SEL_RAW;  rdOk = 1'b1; end
      ADDR_W'(OFF_MIS):  begin sel = SEL_MIS;  rdOk = 1'b1; end
      ADDR_W'(OFF_CLR):  begin sel = SEL_CLR;  wrOk = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (busSize)
      2'd0:    sizeMask = 32'h0000_00FF;
      2'd1:    sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  end

  assign accept = busValid && (busSize != 2'd3) && (busWrite ? wrOk : rdOk);
  assign busErr = busValid && !accept;

  always_comb begin
    strb        = '0;
    strb.wdata  = busWdata & sizeMask;
    strb.rdSel  = SEL_NONE;
    if (accept && busWrite) begin
      strb.wrData = (sel == SEL_DATA);
      strb.wrIbrd = (sel == SEL_IBRD);
      strb.wrFbrd = (sel == SEL_FBRD);
      strb.wrLcrh = (sel == SEL_LCRH);
      strb.wrCtrl = (sel == SEL_CTRL);
      strb.wrFlvl = (sel == SEL_FLVL);
      strb.wrMask = (sel == SEL_MASK);
      strb.wrClr  = (sel == SEL_CLR);
    end
    if (accept && !busWrite) begin
      strb.rdSel  = sel;
      strb.rdData = (sel == SEL_DATA);
    end
  end

  assign busRdata = (accept && !busWrite) ? (regRdata & sizeMask) : 32'd0;

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == 32'd0)) else $error("rejected access returned data"); // R11

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> !(strb.wrData || strb.wrMask || strb.wrClr || strb.wrCtrl)) else $error("rejected access wrote"); // R11

endmodule

// File: rtl/uart_front_dpath.sv
module uart_front_dpath
  import uart_front_pkg::*;
#(
  parameter int unsigned DELAY = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobes_t    strb,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        eotEnable,
  output logic [31:0] regRdata,
  output logic        rxTake,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        eotPulse,
  output logic        irq
);

  localparam int unsigned CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [31:0]      ctrlReg;
  logic [15:0]      ibrdReg;
  logic [5:0]       fbrdReg;
  logic [7:0]       lcrhReg;
  logic [5:0]       flvlReg;
  logic [INT_W-1:0] maskReg;
  logic [INT_W-1:0] rawReg;
  logic [INT_W-1:0] misReg;
  logic             pending;
  logic [CNT_W-1:0] cnt;
  logic             irqReg;
  logic             rxPrev;

  logic             rxRise;
  logic             armReq;
  logic             fire;
  logic [INT_W-1:0] setBits;
  logic [INT_W-1:0] clrBits;
  logic [INT_W-1:0] rawNext;
  logic [INT_W-1:0] misCalc;

  assign rxRise = rxValid && !rxPrev;
  assign fire   = pending && (cnt == CNT_ONE);

  always_comb begin
    setBits = '0;
    if (strb.wrData || (strb.wrMask && strb.wdata[BIT_TX])) setBits[BIT_TX] = 1'b1;
    if (rxRise) begin
      setBits[BIT_RX] = 1'b1;
      setBits[BIT_RT] = 1'b1;
    end
  end

  assign clrBits = strb.wrClr ? strb.wdata[INT_W-1:0] : '0;
  assign rawNext = (rawReg & ~clrBits) | setBits;
  assign armReq  = (strb.wrData && maskReg[BIT_TX])
                || (strb.wrMask && strb.wdata[BIT_TX])
                || rxRise;
  assign misCalc = strb.wrClr ? ((rawReg & ~clrBits) & maskReg) : (rawReg & maskReg);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RST;
      ibrdReg <= '0;
      fbrdReg <= '0;
      lcrhReg <= '0;
      flvlReg <= FLVL_RST;
      maskReg <= '0;
    end else begin
      if (strb.wrCtrl) ctrlReg <= strb.wdata;
      if (strb.wrIbrd) ibrdReg <= strb.wdata[15:0];
      if (strb.wrFbrd) fbrdReg <= strb.wdata[5:0];
      if (strb.wrLcrh) lcrhReg <= strb.wdata[7:0];
      if (strb.wrFlvl) flvlReg <= strb.wdata[5:0];
      if (strb.wrMask) maskReg <= strb.wdata[INT_W-1:0];
    end
  end

  // interrupt state and delay counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawReg  <= '0;
      misReg  <= '0;
      pending <= 1'b0;
      cnt     <= '0;
      irqReg  <= 1'b0;
      rxPrev  <= 1'b0;
    end else begin
      rxPrev <= rxValid;
      rawReg <= rawNext;
      if (pending && !fire) begin
        cnt <= cnt - CNT_ONE;
      end else if (armReq) begin
        pending <= 1'b1;
        cnt     <= CNT_LOAD;
      end else if (fire) begin
        pending <= 1'b0;
        cnt     <= '0;
      end
      if (strb.wrClr || fire) misReg <= misCalc;
      if (strb.wrClr && ((misCalc & IRQ_SRC) == '0)) irqReg <= 1'b0;
      else if (fire) irqReg <= |(misCalc & IRQ_SRC);
    end
  end

  // outgoing stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid  <= 1'b0;
      txData   <= '0;
      eotPulse <= 1'b0;
    end else begin
      txValid  <= strb.wrData;
      eotPulse <= strb.wrData && eotEnable && (strb.wdata[7:0] == 8'h04);
      if (strb.wrData) txData <= strb.wdata[7:0];
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_DATA: regRdata = {24'd0, rxValid ? rxData : 8'd0};
      SEL_FLAG: regRdata = {24'd0, 1'b1, 2'b00, !rxValid, 3'b000, 1'b1};
      SEL_IBRD: regRdata = {16'd0, ibrdReg};
      SEL_FBRD: regRdata = {26'd0, fbrdReg};
      SEL_LCRH: regRdata = {24'd0, lcrhReg};
      SEL_CTRL: regRdata = ctrlReg;
      SEL_FLVL: regRdata = {26'd0, flvlReg};
      SEL_MASK: regRdata = {21'd0, maskReg};
      SEL_RAW:  regRdata = {21'd0, rawReg};
      SEL_MIS:  regRdata = {21'd0, misReg};
      default:  regRdata = 32'd0;
    endcase
  end

  assign rxTake = strb.rdData && rxValid;
  assign irq    = irqReg;

  AST_DATA_SETS_TX: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> rawReg[BIT_TX]) else $error("data write left tx raw clear"); // R2

  AST_RX_SETS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (rxRise && !strb.wrClr) |=> (rawReg[BIT_RX] && rawReg[BIT_RT])) else $error("rx arrival bits"); // R4

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqReg |-> ((misReg & IRQ_SRC) != '0)) else $error("irq without masked source"); // R5

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !fire) |=> (pending && (cnt == $past(cnt) - CNT_ONE))) else $error("delay re-armed"); // R6

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_front_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DELAY  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxTake,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              eotEnable,
  output logic              eotPulse,
  output logic              irq
);

  strobes_t    strb;
  logic [31:0] regRdata;

  uart_front_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWdata (busWdata),
    .regRdata (regRdata),
    .strb     (strb),
    .busRdata (busRdata),
    .busErr   (busErr)
  );

  uart_front_dpath #(.DELAY(DELAY)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rxValid   (rxValid),
    .rxData    (rxData),
    .eotEnable (eotEnable),
    .regRdata  (regRdata),
    .rxTake    (rxTake),
    .txValid   (txValid),
    .txData    (txData),
    .eotPulse  (eotPulse),
    .irq       (irq)
  );

endmodule

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DELAY  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [1:0]        busSize = 2'd2;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              busErr;
  logic              rxValid = 1'b0;
  logic [7:0]        rxData = '0;
  logic              rxTake;
  logic              txValid;
  logic [7:0]        txData;
  logic              eotEnable = 1'b0;
  logic              eotPulse;
  logic              irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic lastErr;
  logic lastTake;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  uart_regfront #(.ADDR_W(ADDR_W), .DELAY(DELAY)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr), .rxValid(rxValid), .rxData(rxData),
    .rxTake(rxTake), .txValid(txValid), .txData(txData), .eotEnable(eotEnable),
    .eotPulse(eotPulse), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rstN && busValid && !busWrite && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check({it.tag, " data"}, busRdata, it.data);
      check({it.tag, " err"}, {31'd0, busErr}, {31'd0, it.err});
    end
  end

  task automatic doWrite(logic [11:0] addr, logic [1:0] size, logic [31:0] data);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = 1'b1; busAddr = addr; busSize = size; busWdata = data;
    @(negedge clk);
    lastErr = busErr;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(logic [11:0] addr, logic [1:0] size, logic [31:0] exp,
                        logic expErr, string tag);
    expItem_t it;
    it.data = exp; it.err = expErr; it.tag = tag;
    expQ.push_back(it);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = 1'b0; busAddr = addr; busSize = size;
    @(negedge clk);
    lastTake = rxTake;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    doRead(12'h030, 2'd2, 32'h300, 1'b0, "R1 ctrl");
    doRead(12'h034, 2'd2, 32'h12,  1'b0, "R1 level");
    doRead(12'h024, 2'd2, 32'h0,   1'b0, "R1 ibrd");
    doRead(12'h028, 2'd2, 32'h0,   1'b0, "R1 fbrd");
    doRead(12'h02C, 2'd2, 32'h0,   1'b0, "R1 lcrh");
    doRead(12'h038, 2'd2, 32'h0,   1'b0, "R1 mask");
    doRead(12'h03C, 2'd2, 32'h0,   1'b0, "R1 raw");
    doRead(12'h040, 2'd2, 32'h0,   1'b0, "R1 mis");

    // R8 / R9 with nothing waiting
    doRead(12'h018, 2'd2, 32'h91, 1'b0, "R8 flags empty");
    doRead(12'h000, 2'd2, 32'h0,  1'b0, "R9 data empty");
    check("R9 no take", {31'd0, lastTake}, 32'd0);

    // R2 data write with mask clear
    doWrite(12'h000, 2'd0, 32'hABCD_1241);
    @(negedge clk);
    check("R2 txValid", {31'd0, txValid}, 32'd1);
    check("R2 txData", {24'd0, txData}, 32'h41);
    @(negedge clk);
    check("R2 txValid one cycle", {31'd0, txValid}, 32'd0);
    doRead(12'h03C, 2'd2, 32'h20, 1'b0, "R2 raw tx");
    check("R2 irq stays low", {31'd0, irq}, 32'd0);

    // R10 size masking
    doWrite(12'h024, 2'd0, 32'h0000_1234);
    doRead(12'h024, 2'd2, 32'h34, 1'b0, "R10 byte write");
    doWrite(12'h024, 2'd2, 32'hFFFF_1234);
    doRead(12'h024, 2'd2, 32'h1234, 1'b0, "R10 word write 16b reg");
    doRead(12'h024, 2'd0, 32'h34, 1'b0, "R10 byte read");
    doWrite(12'h030, 2'd1, 32'h5678_9ABC);
    doRead(12'h030, 2'd2, 32'h9ABC, 1'b0, "R10 half write");
    doWrite(12'h030, 2'd2, 32'h0000_0300);

    // R7 clear raw tx
    doWrite(12'h044, 2'd2, 32'h20);
    doRead(12'h03C, 2'd2, 32'h0, 1'b0, "R7 raw cleared");

    // R3 / R5 mask write arms; expiry edge
    doWrite(12'h038, 2'd2, 32'h20);
    repeat (DELAY - 1) @(posedge clk);
    @(negedge clk);
    check("R5 irq before expiry", {31'd0, irq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R5 irq at expiry", {31'd0, irq}, 32'd1);
    doRead(12'h03C, 2'd2, 32'h20, 1'b0, "R3 raw tx from mask");
    doRead(12'h040, 2'd2, 32'h20, 1'b0, "R5 mis");

    // R7 full clear drops line
    doWrite(12'h044, 2'd2, 32'h20);
    @(negedge clk);
    check("R7 irq dropped", {31'd0, irq}, 32'd0);

    // R6 second arm while pending does not extend
    doWrite(12'h000, 2'd0, 32'h11);
    doWrite(12'h000, 2'd0, 32'h22);
    repeat (DELAY - 3) @(posedge clk);
    @(negedge clk);
    check("R6 irq before first expiry", {31'd0, irq}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R6 irq at first expiry", {31'd0, irq}, 32'd1);
    doWrite(12'h044, 2'd2, 32'h70);
    @(negedge clk);
    check("R7 irq low after clear", {31'd0, irq}, 32'd0);

    // R4 receive arrival inside a pending window
    doWrite(12'h038, 2'd2, 32'h70);
    rxData = 8'h5A; rxValid = 1'b1;
    repeat (DELAY + 3) @(posedge clk);
    @(negedge clk);
    check("R4 irq", {31'd0, irq}, 32'd1);
    doRead(12'h03C, 2'd2, 32'h70, 1'b0, "R4 raw rx rt tx");
    doRead(12'h040, 2'd2, 32'h70, 1'b0, "R5 mis all");

    // R7 partial clear keeps the line
    doWrite(12'h044, 2'd2, 32'h10);
    @(negedge clk);
    check("R7 irq held", {31'd0, irq}, 32'd1);
    doRead(12'h040, 2'd2, 32'h60, 1'b0, "R7 mis partial");

    // R8 / R9 with byte waiting
    doRead(12'h018, 2'd2, 32'h81, 1'b0, "R8 flags full");
    doRead(12'h000, 2'd2, 32'h5A, 1'b0, "R9 data byte");
    check("R9 take", {31'd0, lastTake}, 32'd1);
    rxValid = 1'b0;
    doWrite(12'h044, 2'd2, 32'h60);
    @(negedge clk);
    check("R7 irq low", {31'd0, irq}, 32'd0);

    // R11 rejected accesses
    doRead(12'h008, 2'd2, 32'h0, 1'b1, "R11 undecoded read");
    doRead(12'h044, 2'd2, 32'h0, 1'b1, "R11 clear read");
    doRead(12'h030, 2'd3, 32'h0, 1'b1, "R11 size3 read");
    doWrite(12'h030, 2'd3, 32'hFFFF);
    check("R11 size3 write err", {31'd0, lastErr}, 32'd1);
    doRead(12'h030, 2'd2, 32'h300, 1'b0, "R11 ctrl unchanged");
    doWrite(12'h03C, 2'd2, 32'h70);
    check("R11 raw write err", {31'd0, lastErr}, 32'd1);
    doRead(12'h03C, 2'd2, 32'h0, 1'b0, "R11 raw unchanged");

    // R12 end of transmission
    eotEnable = 1'b1;
    doWrite(12'h000, 2'd0, 32'h04);
    @(negedge clk);
    check("R12 eot pulse", {31'd0, eotPulse}, 32'd1);
    @(negedge clk);
    check("R12 eot one cycle", {31'd0, eotPulse}, 32'd0);
    doWrite(12'h000, 2'd0, 32'h05);
    @(negedge clk);
    check("R12 other byte", {31'd0, eotPulse}, 32'd0);
    eotEnable = 1'b0;
    doWrite(12'h000, 2'd0, 32'h04);
    @(negedge clk);
    check("R12 disabled", {31'd0, eotPulse}, 32'd0);

    repeat (2) @(posedge clk);
    check("queue drained", expQ.size(), 32'd0);
    finishRun();
  end

endmodule